// File: doc/BRIEF.md
# Tagged-FIFO Parallel Port Transmitter

This block is the host-side output engine of a printer-style parallel port. A 3-bit mode input picks one of four behaviours. The two register modes (`000` standard output and `001` bidirectional) copy a host data write straight onto the 8-bit data pins, and software drives the control lines. The two FIFO modes (`010` output-only and `011` tagged) buffer bytes in a 16-deep, 9-bit queue. A hardware state machine drains that queue onto the data pins, pacing each byte with an active-low strobe against the peripheral's busy line.

In the tagged mode every entry carries a ninth bit. The write source sets this bit, and it is presented on the auto-feed line together with the byte, so the peripheral can tell command bytes from data bytes. The block also drives the direction pin. It reports whether the control lines should be open-drain or totem-pole, and it keeps a sticky flag for writes lost to a full queue.

Host data arrives on one valid/ready stream, `wr_*`. A beat transfers on a clock where `wr_valid_i` is high. `wr_ready_o` drops only while a FIFO mode is active and the queue holds 16 entries. A source that ignores this and presents a beat anyway loses the beat, and the overflow flag is raised. In every other case the beat is consumed, or ignored where the mode has no use for it.

Top module: `pport_tx`

## Requirements
- R1: After reset the mode is `000`, the data pins read `0x00`, direction is 0, strobe is high, the open-drain indication is 1, the queue is empty, overflow is 0 and ready is 1.
- R2: In modes `000` and `001`, a beat with source 0 (base offset) appears on `pd_o` one clock after it is accepted. In these modes, beats with source 1 (upper offset) or 2 (DMA) leave `pd_o` unchanged and the queue empty.
- R3: `pdir_o` is 0 in modes `000` and `010`. In modes `001` and `011` it equals the stored direction bit.
- R4: A direction update (`dir_wr_i`) changes the stored direction bit only while the mode is `001`. In any other mode it is ignored.
- R5: `ctl_opendrain_o` is 1 in mode `000` and 0 in every other mode.
- R6: In mode `010`, beats with source 1 or 2 enter the queue and beats with source 0 are ignored.
- R7: In mode `011`, a source 0 beat is queued with tag 0 and a source 1 or 2 beat with tag 1. With direction 0, the tag appears as the `autofd_n_o` level from the same clock as its byte. In mode `010`, `autofd_n_o` follows `sw_ctl_i[1]`.
- R8: In a FIFO transfer, the byte is on `pd_o` for one clock before strobe falls. Strobe stays low until busy has been seen high, and it rises only after that. The byte is stable while strobe is low.
- R9: Queued bytes leave in write order, with none lost or repeated, including a full queue of 16.
- R10: A beat aimed at the queue while it holds 16 entries is dropped, and `overflow_o` rises and stays high until reset. `wr_ready_o` is 0 exactly then.
- R11: A change of `mode_i` empties the queue and returns the handshake to idle with strobe high, and no queued byte is sent afterwards.
- R12: A transfer starts only when busy is low. Bytes wait in the queue while busy stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Operating mode |
| dir_wr_i | input | 1 | Pulse that requests a direction-bit update |
| dir_bit_i | input | 1 | New direction bit value |
| sw_ctl_i | input | 4 | Software control levels: [0] strobe, [1] auto-feed, [2] init, [3] select-in |
| wr_valid_i | input | 1 | Host beat valid |
| wr_ready_o | output | 1 | Beat can be taken without loss |
| wr_src_i | input | 2 | Beat source: 0 base offset, 1 upper offset, 2 DMA |
| wr_data_i | input | 8 | Beat byte |
| busy_i | input | 1 | Peripheral busy |
| pd_o | output | 8 | Data pins |
| pdir_o | output | 1 | Data direction pin |
| strobe_n_o | output | 1 | Strobe, active low |
| autofd_n_o | output | 1 | Auto-feed line, which carries the tag in mode `011` |
| init_n_o | output | 1 | Init line |
| slctin_n_o | output | 1 | Select-in line |
| ctl_opendrain_o | output | 1 | 1 when the control lines are open-drain |
| fifo_empty_o | output | 1 | Queue empty |
| overflow_o | output | 1 | Sticky lost-write flag |

## Verification
A register-mode byte lands on `pd_o` one clock after its beat is accepted. Mode and direction effects show one clock after the input changes, because the mode is registered first. The bench samples on the falling edge, so it reads these results half a clock after the edge that produces them. In FIFO modes, a queued byte is popped at the earliest one clock after its push, and strobe falls one clock after the pop. Rather than predicting absolute cycles, the scoreboard monitor acts as the peripheral: it samples on each falling edge where strobe goes low and compares the byte and tag against the head of the expected queue. It checks that the byte was already present one sample earlier and stays unchanged until busy is answered. Flush and busy-hold cases are checked over fixed windows in which no strobe may appear.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [2:0] MODE_STD   = 3'b000;
  localparam logic [2:0] MODE_BIDIR = 3'b001;
  localparam logic [2:0] MODE_FIFO  = 3'b010;
  localparam logic [2:0] MODE_ECP   = 3'b011;

  localparam logic [1:0] SRC_BASE = 2'd0;
  localparam logic [1:0] SRC_HIGH = 2'd1;
  localparam logic [1:0] SRC_DMA  = 2'd2;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_SETUP = 2'd1,
    HS_STB   = 2'd2,
    HS_REL   = 2'd3
  } hs_state_t;
endpackage

// File: rtl/pp_fifo.sv
module pp_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pp_wr_dec.sv
module pp_wr_dec
  import pp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        mode,
  input  logic              flush,
  input  logic              valid,
  input  logic [1:0]        src,
  input  logic [DATA_W-1:0] data,
  input  logic              full,
  output logic              ready,
  output logic              push,
  output logic [DATA_W:0]   push_entry,
  output logic              reg_load,
  output logic              drop
);
  logic fifo_mode, reg_mode, src_ok, to_fifo;

  always_comb begin
    fifo_mode  = (mode == MODE_FIFO) || (mode == MODE_ECP);
    reg_mode   = (mode == MODE_STD) || (mode == MODE_BIDIR);
    src_ok     = (src == SRC_BASE) || (src == SRC_HIGH) || (src == SRC_DMA);
    to_fifo    = valid && !flush && src_ok &&
                 ((mode == MODE_ECP) || (mode == MODE_FIFO && src != SRC_BASE));
    push       = to_fifo && !full;
    drop       = to_fifo && full;
    push_entry = {(src != SRC_BASE), data};
    reg_load   = valid && !flush && reg_mode && (src == SRC_BASE);
    ready      = !(fifo_mode && full);
  end
endmodule

// File: rtl/pp_handshake.sv
module pp_handshake
  import pp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic go,
  input  logic busy,
  output logic pop,
  output logic strobe_n
);
  hs_state_t state, nxt;

  always_comb begin
    nxt = state;
    pop = 1'b0;
    case (state)
      HS_IDLE:  if (go && !busy) begin pop = 1'b1; nxt = HS_SETUP; end
      HS_SETUP: nxt = HS_STB;
      HS_STB:   if (busy) nxt = HS_REL;
      HS_REL:   if (!busy) nxt = HS_IDLE;
      default:  nxt = HS_IDLE;
    endcase
    if (clear) begin
      nxt = HS_IDLE;
      pop = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= HS_IDLE;
    else        state <= nxt;
  end

  assign strobe_n = (state != HS_STB);
endmodule

// File: rtl/pport_tx.sv
module pport_tx
  import pp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              dir_wr_i,
  input  logic              dir_bit_i,
  input  logic [3:0]        sw_ctl_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [1:0]        wr_src_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic [DATA_W-1:0] pd_o,
  output logic              pdir_o,
  output logic              strobe_n_o,
  output logic              autofd_n_o,
  output logic              init_n_o,
  output logic              slctin_n_o,
  output logic              ctl_opendrain_o,
  output logic              fifo_empty_o,
  output logic              overflow_o
);
  localparam int EW = DATA_W + 1;

  logic [2:0]        mode_q;
  logic              dir_q, tag_q, ovf_q;
  logic [DATA_W-1:0] pd_q;
  logic              mode_chg, fifo_mode, ecp_fwd, fwd_ok;
  logic              push, pop, reg_load, drop, full, empty, hs_strobe_n;
  logic [EW-1:0]     push_entry, head;

  assign mode_chg  = (mode_i != mode_q);
  assign fifo_mode = (mode_q == MODE_FIFO) || (mode_q == MODE_ECP);
  assign ecp_fwd   = (mode_q == MODE_ECP) && !dir_q;
  assign fwd_ok    = (mode_q == MODE_FIFO) || ecp_fwd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_STD;
      dir_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (dir_wr_i && mode_q == MODE_BIDIR) dir_q <= dir_bit_i;
      if (drop) ovf_q <= 1'b1;
    end
  end

  pp_wr_dec #(.DATA_W(DATA_W)) wr_dec_i (
    .mode(mode_q), .flush(mode_chg), .valid(wr_valid_i), .src(wr_src_i),
    .data(wr_data_i), .full(full), .ready(wr_ready_o), .push(push),
    .push_entry(push_entry), .reg_load(reg_load), .drop(drop)
  );

  pp_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(mode_chg), .push(push),
    .wdata(push_entry), .pop(pop), .rdata(head), .full(full), .empty(empty)
  );

  pp_handshake hs_i (
    .clk(clk), .rst_n(rst_n), .clear(mode_chg),
    .go(fwd_ok && !empty), .busy(busy_i), .pop(pop), .strobe_n(hs_strobe_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q  <= '0;
      tag_q <= 1'b1;
    end else if (pop) begin
      pd_q  <= head[DATA_W-1:0];
      tag_q <= head[DATA_W];
    end else if (reg_load) begin
      pd_q  <= wr_data_i;
    end
  end

  assign pd_o            = pd_q;
  assign pdir_o          = ((mode_q == MODE_BIDIR) || (mode_q == MODE_ECP)) ? dir_q : 1'b0;
  assign strobe_n_o      = fifo_mode ? hs_strobe_n : sw_ctl_i[0];
  assign autofd_n_o      = ecp_fwd ? tag_q : sw_ctl_i[1];
  assign init_n_o        = sw_ctl_i[2];
  assign slctin_n_o      = sw_ctl_i[3];
  assign ctl_opendrain_o = (mode_q == MODE_STD);
  assign fifo_empty_o    = empty;
  assign overflow_o      = ovf_q;
endmodule

// File: rtl/pport_tx_chk.sv
module pport_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic [2:0] mode_q,
  input logic       busy_i,
  input logic [7:0] pd_o,
  input logic       pdir_o,
  input logic       strobe_n_o,
  input logic       fifo_empty_o,
  input logic       overflow_o,
  input logic       wr_ready_o
);
  logic fifo_m;
  assign fifo_m = (mode_q == 3'b010) || (mode_q == 3'b011);

  // R8
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_m && !strobe_n_o && $past(!strobe_n_o) |-> $stable(pd_o));
  // R8
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_m && $fell(strobe_n_o) |-> $stable(pd_o));
  // R8
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_m && $rose(strobe_n_o) && $stable(mode_q) |-> $past(busy_i));
  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != mode_q) |=> fifo_empty_o);
  // R11
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != mode_q) && (mode_i[2:1] == 2'b01) |=> strobe_n_o);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  // R10
  full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready_o |-> !fifo_empty_o);
  // R3
  fwd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_m && !strobe_n_o |-> !pdir_o);
endmodule

bind pport_tx pport_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_q(mode_q),
  .busy_i(busy_i), .pd_o(pd_o), .pdir_o(pdir_o), .strobe_n_o(strobe_n_o),
  .fifo_empty_o(fifo_empty_o), .overflow_o(overflow_o), .wr_ready_o(wr_ready_o)
);

// File: tb/pport_tx_tb_top.sv
module pport_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       dir_wr = 1'b0, dir_bit = 1'b0;
  logic [3:0] sw_ctl = 4'hF;
  logic       wr_valid = 1'b0;
  logic [1:0] wr_src = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       busy_per = 1'b0, busy_hold = 1'b0;
  logic       busy;
  logic       wr_ready, pdir, strobe_n, autofd_n, init_n, slctin_n, od, empty, ovf;
  logic [7:0] pd;

  int checks = 0;
  int errs = 0;
  int mon_st = 0;
  int mon_cnt = 0;
  logic [7:0] hold_pd, prev_pd;
  logic       prev_stb;
  logic [8:0] exp_q [$];
  logic [8:0] got;

  assign busy = busy_per | busy_hold;
  always #2 clk = ~clk;

  pport_tx dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_wr_i(dir_wr), .dir_bit_i(dir_bit),
    .sw_ctl_i(sw_ctl), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_src_i(wr_src),
    .wr_data_i(wr_data), .busy_i(busy), .pd_o(pd), .pdir_o(pdir), .strobe_n_o(strobe_n),
    .autofd_n_o(autofd_n), .init_n_o(init_n), .slctin_n_o(slctin_n),
    .ctl_opendrain_o(od), .fifo_empty_o(empty), .overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] src, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_src = src; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // driver: queue a beat and record the expected {autofd level, byte}
  task automatic send(input logic [1:0] src, input logic [7:0] d, input logic lvl);
    exp_q.push_back({lvl, d});
    wr(src, d);
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode = m;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_dir(input logic b);
    @(negedge clk); dir_wr = 1'b1; dir_bit = b;
    @(negedge clk); dir_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || mon_st != 0) && n < 3000) begin
      @(negedge clk); n++;
    end
    chk(n < 3000, req, exp_q.size(), 0);
  endtask

  // monitor: plays the peripheral and scores each strobed byte
  initial begin
    prev_stb = 1'b1; prev_pd = 8'h00; hold_pd = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mon_st = 0; busy_per = 1'b0;
      end else begin
        if (busy && prev_stb && !strobe_n) chk(1'b0, "R12 strobe while busy", 0, 1);
        case (mon_st)
          0: if (!strobe_n) begin
               chk(prev_pd == pd, "R8 setup", prev_pd, pd);
               if (exp_q.size() == 0) chk(1'b0, "R9/R11 unexpected byte", pd, 0);
               else begin
                 got = exp_q.pop_front();
                 chk({autofd_n, pd} == got, "R9/R7 byte+tag", {autofd_n, pd}, got);
               end
               hold_pd = pd; mon_cnt = 2; mon_st = 1;
             end
          1: begin
               if (pd != hold_pd) chk(1'b0, "R8 hold", pd, hold_pd);
               if (strobe_n) chk(1'b0, "R8 early release", 1, 0);
               if (mon_cnt == 0) begin busy_per = 1'b1; mon_st = 2; end
               else mon_cnt--;
             end
          2: if (strobe_n) begin mon_cnt = 3; mon_st = 3; end
          default: begin
               if (!strobe_n) chk(1'b0, "R8 restrobe before busy low", 0, 1);
               if (mon_cnt == 0) begin busy_per = 1'b0; mon_st = 0; end
               else mon_cnt--;
             end
        endcase
        prev_pd = pd; prev_stb = strobe_n;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int stb_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pd == 8'h00 && pdir == 0 && strobe_n == 1, "R1 pins", {pd, pdir, strobe_n}, 9'h001);
    chk(od == 1 && empty == 1 && ovf == 0 && wr_ready == 1, "R1 flags", {od, empty, ovf, wr_ready}, 4'b1101);

    // R2 register mode 000
    wr(2'd0, 8'hA5);
    chk(pd == 8'hA5, "R2 base latch", pd, 8'hA5);
    wr(2'd1, 8'h3C); wr(2'd2, 8'h77);
    chk(pd == 8'hA5 && empty, "R2 upper/dma ignored", pd, 8'hA5);
    chk(od == 1, "R5 opendrain mode000", od, 1);

    // R4 direction locked outside 001
    set_dir(1'b1);
    set_mode(3'b001);
    chk(pdir == 0, "R4 dir write ignored in 000", pdir, 0);
    chk(od == 0, "R5 totem mode001", od, 0);
    set_dir(1'b1);
    chk(pdir == 1, "R3 pdir follows dir in 001", pdir, 1);
    wr(2'd0, 8'h5A);
    chk(pd == 8'h5A, "R2 base latch 001", pd, 8'h5A);

    set_mode(3'b011);
    chk(pdir == 1, "R3 pdir follows dir in 011", pdir, 1);
    set_dir(1'b0);
    chk(pdir == 1, "R4 dir write ignored in 011", pdir, 1);
    set_mode(3'b010);
    chk(pdir == 0 && od == 0, "R3/R5 mode010 pdir low", {pdir, od}, 0);
    set_mode(3'b001);
    set_dir(1'b0);

    // R6 / R7 mode 010 with software auto-feed low
    set_mode(3'b010);
    sw_ctl = 4'b1101;
    send(2'd1, 8'h11, 1'b0);
    wr(2'd0, 8'h99);
    send(2'd2, 8'h22, 1'b0);
    send(2'd1, 8'h33, 1'b0);
    drain("R6 drain mode010");
    sw_ctl = 4'hF;

    // R7 tagged mode: mixed sources
    set_mode(3'b011);
    for (int i = 0; i < 9; i++) begin
      logic [1:0] s;
      s = 2'(i % 3);
      send(s, 8'h40 + 8'(i), (s != 2'd0));
    end
    drain("R7 drain mode011");

    // R12 busy held: nothing starts
    busy_hold = 1'b1;
    send(2'd0, 8'hC0, 1'b0);
    stb_seen = 0;
    repeat (20) begin @(negedge clk); if (!strobe_n) stb_seen++; end
    chk(stb_seen == 0 && !empty, "R12 wait for busy low", stb_seen, 0);

    // R10 fill to 16, overflow on 17th
    for (int i = 1; i < 16; i++) send(2'd1, 8'hC0 + 8'(i), 1'b1);
    chk(wr_ready == 0, "R10 ready low when full", wr_ready, 0);
    chk(ovf == 0, "R10 no overflow yet", ovf, 0);
    wr(2'd1, 8'hEE);
    chk(ovf == 1, "R10 overflow set", ovf, 1);
    busy_hold = 1'b0;
    drain("R9 drain full queue");
    chk(ovf == 1 && wr_ready == 1, "R10 overflow sticky", {ovf, wr_ready}, 2'b11);

    // R11 mode change flushes
    busy_hold = 1'b1;
    wr(2'd0, 8'hD1); wr(2'd1, 8'hD2); wr(2'd2, 8'hD3);
    chk(!empty, "R11 queue loaded", empty, 0);
    set_mode(3'b010);
    chk(empty && strobe_n, "R11 flushed", {empty, strobe_n}, 2'b11);
    busy_hold = 1'b0;
    stb_seen = 0;
    repeat (30) begin @(negedge clk); if (!strobe_n) stb_seen++; end
    chk(stb_seen == 0, "R11 nothing sent after flush", stb_seen, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule